// File: doc/BRIEF.md
# Store Queue with Byte-Range Load Forwarding

This block holds a short, ordered list of stores that have executed but not yet been written to the cache. Each store is kept with its byte address, its width and its data. A load presented on the lookup port is checked against every live store at once. The checks compare byte ranges, so accesses that are unaligned or of different sizes are handled correctly, not only accesses at the same address.

Every store is put in one of three classes: it covers every byte the load reads, it covers only some of them, or it shares no byte with the load. The youngest store that touches the load decides the outcome. If it covers the whole load, its bytes are shifted into place and forwarded. If it covers only part of the load, the load must stall until that store has drained. If no store touches the load, the load reads the cache. Stores are appended at the tail and leave from the head, one for each commit pulse.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty (`sq_empty`=1, `sq_full`=0) and `res_valid`=0, `res_kind`=0, `res_data`=0.
- R2: When `st_alloc` is high and the queue holds fewer than DEPTH (8) stores at that edge, a store is appended. Its size code gives 1, 2, 4 or 8 bytes for codes 0, 1, 2, 3. When the queue is full the allocation is ignored, and `sq_full` is high exactly while 8 stores are held.
- R3: A `st_commit` pulse removes the oldest store. A commit while empty is ignored. `sq_empty` is high exactly while no store is held.
- R4: `res_valid` is high in exactly the cycle after a cycle with `ld_valid` high, and the result refers to that load.
- R5: When the deciding store contains every byte of the load, `res_kind`=1 (forward). Byte k of `res_data` is the store's byte (load address − store address + k) for k below the load size, and the bytes above the load size are zero.
- R6: When the deciding store covers some but not all of the load's bytes, `res_kind`=2 (stall) and `res_data`=0.
- R7: When no held store shares a byte with the load, `res_kind`=0 (cache read) and `res_data`=0.
- R8: Among the stores that share at least one byte with the load, the most recently allocated one decides the outcome, even when an older store would contain the load.
- R9: Byte membership is start ≤ byte < start + size. For example, a 4-byte load at offsets 0 to 4 inside an 8-byte store forwards, and one at offset 5 stalls.
- R10: A lookup sees only the stores held before its clock edge. A store allocated in the same cycle as the load does not take part, and a store committed in that cycle still does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_alloc | input | 1 | Append a store this cycle |
| st_addr | input | ADDR_W (16) | Byte address of the new store |
| st_szc | input | 2 | Store size code (0:1, 1:2, 2:4, 3:8 bytes) |
| st_data | input | 8*DBYTES (64) | Store data, byte 0 in bits 7:0 |
| st_commit | input | 1 | Retire the oldest store |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W (16) | Byte address of the load |
| ld_szc | input | 2 | Load size code (same coding as stores) |
| res_valid | output | 1 | Lookup result valid |
| res_kind | output | 2 | 0 cache read, 1 forward, 2 stall |
| res_data | output | 8*DBYTES (64) | Forwarded data, zero unless forwarding |
| sq_full | output | 1 | Queue holds DEPTH stores |
| sq_empty | output | 1 | Queue holds no store |

## Verification
The assertions assume that no access range runs past the top of the address space, that is, address plus size stays at or below 2^ADDR_W. The comparators extend addresses by one bit and do not model wraparound. The stimulus keeps every address inside small windows far below the top, and the random phase packs its stores and loads into a 24-byte window so that full, partial and disjoint cases all occur often. Allocations while full and commits while empty are driven on purpose. The assertions only require that the resulting state stays within bounds.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef enum logic [1:0] {
        RES_CACHE = 2'd0,
        RES_FWD   = 2'd1,
        RES_STALL = 2'd2
    } res_kind_e;

endpackage

// File: rtl/sq_range_cmp.sv
// Compares one store's byte range against the load's byte range.
module sq_range_cmp #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 4,
    parameter int OFF_W  = 3
) (
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [LEN_W-1:0]  st_len,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [LEN_W-1:0]  ld_len,
    output logic              hit_any,
    output logic              hit_full,
    output logic [OFF_W-1:0]  offset
);
    localparam int EW = ADDR_W + 1;

    logic [EW-1:0] s_lo, s_hi, l_lo, l_hi;

    always_comb begin
        s_lo     = {1'b0, st_addr};
        l_lo     = {1'b0, ld_addr};
        s_hi     = s_lo + {{(EW-LEN_W){1'b0}}, st_len};
        l_hi     = l_lo + {{(EW-LEN_W){1'b0}}, ld_len};
        // half-open ranges [lo, hi) intersect
        hit_any  = (l_lo < s_hi) && (s_lo < l_hi);
        // load range inside store range
        hit_full = (l_lo >= s_lo) && (l_hi <= s_hi);
        // distance is below DBYTES when contained, so low bits suffice
        offset   = ld_addr[OFF_W-1:0] - st_addr[OFF_W-1:0];
    end
endmodule

// File: rtl/sq_youngest_pick.sv
// Picks the youngest entry among the hits, walking ages from the head.
module sq_youngest_pick #(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3
) (
    input  logic [DEPTH-1:0] hit_vec,
    input  logic [PTR_W-1:0] head,
    output logic             found,
    output logic [PTR_W-1:0] sel
);
    logic [PTR_W-1:0] idx;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PTR_W'(k);
            if (hit_vec[idx]) begin
                found = 1'b1;
                sel   = idx;
            end
        end
    end
endmodule

// File: rtl/sq_align.sv
// Shifts the chosen store's data down by the byte offset, keeps load-size bytes.
module sq_align #(
    parameter int DBYTES = 8,
    parameter int OFF_W  = 3,
    parameter int LEN_W  = 4
) (
    input  logic [8*DBYTES-1:0] st_data,
    input  logic [OFF_W-1:0]    offset,
    input  logic [LEN_W-1:0]    ld_len,
    output logic [8*DBYTES-1:0] fwd_data
);
    logic [8*DBYTES-1:0] shifted;

    always_comb begin
        shifted = st_data >> {offset, 3'b000};
    end

    for (genvar b = 0; b < DBYTES; b++) begin : g_byte
        assign fwd_data[8*b +: 8] = (LEN_W'(b) < ld_len) ? shifted[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue
    import sq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DBYTES = 8,
    localparam int SZC_W = $clog2($clog2(DBYTES) + 1),
    localparam int DW    = 8 * DBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_alloc,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SZC_W-1:0]  st_szc,
    input  logic [DW-1:0]     st_data,
    input  logic              st_commit,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SZC_W-1:0]  ld_szc,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [DW-1:0]     res_data,
    output logic              sq_full,
    output logic              sq_empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int OFF_W = $clog2(DBYTES);
    localparam int LEN_W = OFF_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SZC_W-1:0]  szc;
        logic [DW-1:0]     data;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
        logic             res_v;
        res_kind_e        res_k;
        logic [DW-1:0]    res_d;
    } state_t;

    state_t s_d, s_q;

    logic [DEPTH-1:0] valid_vec, any_raw, full_raw, hit_vec;
    logic [OFF_W-1:0] off_vec [DEPTH];
    logic [LEN_W-1:0] ent_len [DEPTH];
    logic [LEN_W-1:0] ld_len;
    logic [PTR_W-1:0] age;
    logic             found;
    logic [PTR_W-1:0] sel;
    logic [DW-1:0]    fwd_data;
    logic             do_alloc, do_commit;

    assign ld_len = LEN_W'(1) << ld_szc;

    // live entries are the cnt slots starting at head
    always_comb begin
        age = '0;
        for (int i = 0; i < DEPTH; i++) begin
            age          = PTR_W'(i) - s_q.head;
            valid_vec[i] = CNT_W'(age) < s_q.cnt;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign ent_len[i] = LEN_W'(1) << s_q.ent[i].szc;
        sq_range_cmp #(
            .ADDR_W(ADDR_W),
            .LEN_W (LEN_W),
            .OFF_W (OFF_W)
        ) u_cmp (
            .st_addr (s_q.ent[i].addr),
            .st_len  (ent_len[i]),
            .ld_addr (ld_addr),
            .ld_len  (ld_len),
            .hit_any (any_raw[i]),
            .hit_full(full_raw[i]),
            .offset  (off_vec[i])
        );
    end

    assign hit_vec = any_raw & valid_vec;

    sq_youngest_pick #(
        .DEPTH(DEPTH),
        .PTR_W(PTR_W)
    ) u_pick (
        .hit_vec(hit_vec),
        .head   (s_q.head),
        .found  (found),
        .sel    (sel)
    );

    sq_align #(
        .DBYTES(DBYTES),
        .OFF_W (OFF_W),
        .LEN_W (LEN_W)
    ) u_align (
        .st_data (s_q.ent[sel].data),
        .offset  (off_vec[sel]),
        .ld_len  (ld_len),
        .fwd_data(fwd_data)
    );

    assign do_alloc  = st_alloc && (s_q.cnt < CNT_W'(DEPTH));
    assign do_commit = st_commit && (s_q.cnt != '0);

    always_comb begin
        s_d = s_q;
        if (do_alloc) begin
            s_d.ent[s_q.tail].addr = st_addr;
            s_d.ent[s_q.tail].szc  = st_szc;
            s_d.ent[s_q.tail].data = st_data;
            s_d.tail               = s_q.tail + 1'b1;
        end
        if (do_commit) begin
            s_d.head = s_q.head + 1'b1;
        end
        s_d.cnt = s_q.cnt + CNT_W'(do_alloc) - CNT_W'(do_commit);

        s_d.res_v = ld_valid;
        s_d.res_k = RES_CACHE;
        s_d.res_d = '0;
        if (ld_valid && found) begin
            if (full_raw[sel]) begin
                s_d.res_k = RES_FWD;
                s_d.res_d = fwd_data;
            end else begin
                s_d.res_k = RES_STALL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign res_valid = s_q.res_v;
    assign res_kind  = s_q.res_k;
    assign res_data  = s_q.res_d;
    assign sq_full   = (s_q.cnt == CNT_W'(DEPTH));
    assign sq_empty  = (s_q.cnt == '0);

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));

    a_r2_full_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_full && st_alloc && !st_commit) |=> (sq_full && $stable(s_q.tail)));

    a_r3_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_empty && st_commit && !st_alloc) |=> (sq_empty && $stable(s_q.head)));

    a_r4_res_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> res_valid);

    a_r4_res_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !res_valid);

    a_r6_stall_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'd2) |-> (res_data == '0));

    a_r7_cache_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'd0) |-> (res_data == '0));

    a_r8_pick_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (hit_vec[sel] && valid_vec[sel]));

    a_r5_fwd_needs_contain: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !found) |=> (res_kind != 2'd1));
endmodule

// File: tb/sim_store_fwd_queue.sv
`timescale 1ns/1ps
module sim_store_fwd_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_alloc = 1'b0;
    logic [15:0] st_addr = '0;
    logic [1:0]  st_szc = '0;
    logic [63:0] st_data = '0;
    logic        st_commit = 1'b0;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_addr = '0;
    logic [1:0]  ld_szc = '0;
    logic        res_valid;
    logic [1:0]  res_kind;
    logic [63:0] res_data;
    logic        sq_full, sq_empty;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model
    int          m_addr[$];
    int          m_len[$];
    logic [63:0] m_data[$];

    always #2 clk = ~clk;

    store_fwd_queue u0 (
        .clk(clk), .rst_n(rst_n),
        .st_alloc(st_alloc), .st_addr(st_addr), .st_szc(st_szc), .st_data(st_data),
        .st_commit(st_commit),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_szc(ld_szc),
        .res_valid(res_valid), .res_kind(res_kind), .res_data(res_data),
        .sq_full(sq_full), .sq_empty(sq_empty)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    // youngest overlapping store decides; byte-wise membership test
    task automatic expect_load(input int la, input int ll, output int kind, output logic [63:0] d);
        kind = 0;
        d    = '0;
        for (int j = m_addr.size() - 1; j >= 0; j--) begin
            int inb = 0;
            for (int b = 0; b < ll; b++)
                if (m_addr[j] <= la + b && la + b < m_addr[j] + m_len[j]) inb++;
            if (inb > 0) begin
                if (inb == ll) begin
                    kind = 1;
                    for (int b = 0; b < ll; b++)
                        d[8*b +: 8] = m_data[j][8*(la + b - m_addr[j]) +: 8];
                end else begin
                    kind = 2;
                end
                break;
            end
        end
    endtask

    task automatic step(input logic a, input int aa, input int asz, input logic [63:0] ad,
                        input logic c, input logic l, input int la, input int lsz,
                        input string tag);
        int          ek;
        logic [63:0] ed;
        bit          pre_full, pre_empty;
        string       t;
        st_alloc  = a;  st_addr = 16'(aa); st_szc = 2'(asz); st_data = ad;
        st_commit = c;
        ld_valid  = l;  ld_addr = 16'(la); ld_szc = 2'(lsz);
        expect_load(la, 1 << lsz, ek, ed);
        pre_full  = (m_addr.size() == 8);
        pre_empty = (m_addr.size() == 0);
        @(posedge clk);
        if (c && !pre_empty) begin
            void'(m_addr.pop_front()); void'(m_len.pop_front()); void'(m_data.pop_front());
        end
        if (a && !pre_full) begin
            m_addr.push_back(aa); m_len.push_back(1 << asz); m_data.push_back(ad);
        end
        @(negedge clk);
        check("R4 res_valid", 64'(res_valid), 64'(l));
        if (l) begin
            t = (tag != "") ? tag : (ek == 1) ? "R5" : (ek == 2) ? "R6" : "R7";
            check({t, " kind"}, 64'(res_kind), 64'(ek));
            check({t, " data"}, res_data, ed);
        end
        check("R2 sq_full", 64'(sq_full), 64'(m_addr.size() == 8));
        check("R3 sq_empty", 64'(sq_empty), 64'(m_addr.size() == 0));
    endtask

    task automatic idle();
        step(0, 0, 0, '0, 0, 0, 0, 0, "");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 empty", 64'(sq_empty), 64'd1);
        check("R1 full", 64'(sq_full), 64'd0);
        check("R1 res_valid", 64'(res_valid), 64'd0);
        check("R1 res_kind", 64'(res_kind), 64'd0);
        check("R1 res_data", res_data, 64'd0);

        // R2: 8-byte store at 0x100
        step(1, 'h100, 3, 64'h8877665544332211, 0, 0, 0, 0, "");
        // R9: 4-byte loads at offsets 0..4 forward, offset 5 stalls
        for (int o = 0; o <= 4; o++) step(0, 0, 0, '0, 0, 1, 'h100 + o, 2, "R9");
        step(0, 0, 0, '0, 0, 1, 'h105, 2, "R9");
        step(0, 0, 0, '0, 0, 1, 'h107, 0, "R5");
        step(0, 0, 0, '0, 0, 1, 'h0FE, 2, "R6");
        step(0, 0, 0, '0, 0, 1, 'h200, 3, "R7");
        step(0, 0, 0, '0, 0, 1, 'h108, 0, "R9");

        // R8: younger 2-byte store inside the older one
        step(1, 'h102, 1, 64'h000000000000BBAA, 0, 0, 0, 0, "");
        step(0, 0, 0, '0, 0, 1, 'h100, 2, "R8");
        step(0, 0, 0, '0, 0, 1, 'h102, 1, "R8");
        step(0, 0, 0, '0, 0, 1, 'h101, 0, "R8");
        step(0, 0, 0, '0, 0, 1, 'h103, 0, "R8");

        // R10: store allocated in the same cycle as the load is not seen
        step(1, 'h300, 2, 64'h00000000DDCCBBAA, 0, 1, 'h300, 2, "R10");
        step(0, 0, 0, '0, 0, 1, 'h300, 2, "R10");
        // R10: store committed in the load's cycle still seen (oldest is 0x100)
        step(0, 0, 0, '0, 1, 1, 'h104, 2, "R10");
        step(0, 0, 0, '0, 0, 1, 'h104, 2, "R3");

        // R2: fill to full, then an ignored allocation
        while (m_addr.size() < 8) step(1, 'h400 + 16 * m_addr.size(), 3, 64'h0123456789ABCDEF, 0, 0, 0, 0, "");
        step(1, 'h900, 3, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, "");
        step(0, 0, 0, '0, 0, 1, 'h900, 3, "R2");
        // R3: drain, then commit on empty
        while (m_addr.size() > 0) step(0, 0, 0, '0, 1, 0, 0, 0, "");
        step(0, 0, 0, '0, 1, 0, 0, 0, "");
        step(1, 'h500, 0, 64'h5A, 0, 0, 0, 0, "");
        step(0, 0, 0, '0, 0, 1, 'h500, 0, "R3");
        step(0, 0, 0, '0, 1, 0, 0, 0, "");
        idle();

        // random mix in a tight window
        for (int n = 0; n < 600; n++) begin
            logic [63:0] rd;
            rd = {$urandom, $urandom};
            step(($urandom % 3) != 0, 'h40 + ($urandom % 24), $urandom % 4, rd,
                 ($urandom % 4) == 0, ($urandom % 2) == 0, 'h40 + ($urandom % 24), $urandom % 4, "");
        end
        idle();

        done = 1;
        summary();
        $finish;
    end
endmodule